// File: doc/BRIEF.md
# Low-Power Lane Wake-Up Sequencer

This block brings the clock lane and the data lanes of a serial display link out of ultra-low-power mode (ULPM) with no software stepping. One start pulse runs a fixed order. The block first checks that every active lane sits in ULPM. It then turns the PHY PLL on and waits for lock. It raises the exit bits of the power-up control field while the request bits stay high, and waits until the lanes report that they have left ULPM. It holds for one millisecond, releases the whole field, and moves the byte-lane clock from the system PLL to the PHY PLL. Last, it confirms that the lanes are in Stop state.

The PHY, its PLL and the clock multiplexer stay outside the block. They appear as a lock input, a lane-status vector, a PLL-enable output, the four-bit control field and a clock-select output. A configuration input picks one or two data lanes, and that choice changes which status bits are checked at each step. A timeout counter guards every wait. When a wait runs out, the block raises a sticky error and goes back to idle. It does not undo the outputs it has already driven.

Top module: `lane_wake_seq`

## Requirements
- R1: After reset, pll_en_o=0, pwr_ctl_o=4'h0, byteclk_sel_o=0 (0 selects the system PLL), and busy_o, done_o and err_o are all 0.
- R2: Before enabling the PLL, the block requires lane_stat_i[6:1]==0 in one-lane mode (two_lane_i=0), or lane_stat_i[8:1]==0 in two-lane mode. Bits 8 and 7 are ignored in one-lane mode.
- R3: The first output change after a start is pll_en_o going to 1. While the PLL lock input is low, pwr_ctl_o stays 4'h0.
- R4: On the first cycle that pll_lock_i=1, pwr_ctl_o goes directly to 4'hF, so the request bits are never dropped before the exit bits are raised.
- R5: Lane exit is confirmed when lane_stat_i[5] and lane_stat_i[3] are both 1 in one-lane mode. In two-lane mode, lane_stat_i[8], [5] and [3] must all be 1.
- R6: After exit is confirmed, the block holds all outputs unchanged for exactly CLK_HZ/1000 cycles, so pwr_ctl_o reads 4'hF for HOLD+1 cycles when exit is already present at lock.
- R7: At the end of the hold, pwr_ctl_o drops to 4'h0 in one step. byteclk_sel_o goes to 1 (PHY PLL) one cycle later.
- R8: The Stop-state check requires three things:
  - lane_stat_i[6:4]==3'b011 and lane_stat_i[1]==0 in one-lane mode, or lane_stat_i[8:4]==5'b11011 and lane_stat_i[1]==0 in two-lane mode;
  - pll_en_o=1.
  When the check passes, done_o pulses for exactly one cycle. It never pulses otherwise.
- R9: If any wait (ULPM check, lock, lane exit, Stop check) lasts TMO_CYC cycles, err_o is set until reset and busy_o falls. pll_en_o and pwr_ctl_o keep their values.
- R10: A start pulse received while busy_o=1 has no effect on the sequence or its timing.
- R11: busy_o rises the cycle after an accepted start and falls with done_o or with the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| two_lane_i | input | 1 | 1 = two data lanes, 0 = one |
| pll_lock_i | input | 1 | PHY PLL lock indication |
| lane_stat_i | input | 8 | Lane status bits [8:1] |
| pll_en_o | output | 1 | PHY PLL enable |
| pwr_ctl_o | output | 4 | Power-up control field (ULPM request and exit bits) |
| byteclk_sel_o | output | 1 | Byte-lane clock source, 1 = PHY PLL |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Sticky timeout error |

## Verification
Most wrong internal states show up within one cycle at the ports:
- a state that skips a step shows as pll_en_o, pwr_ctl_o or byteclk_sel_o changing in the wrong order or cycle;
- a wrong lane-pattern decode makes a sequence stall until err_o rises after TMO_CYC cycles, or makes one that should stall go ahead.

Hold-counter or timeout-counter faults change the exact number of cycles pwr_ctl_o stays at 4'hF or busy_o stays high, so the bench measures both windows exactly. Sweeping each single status bit in both lane modes exposes any bit the ULPM check decodes wrongly.

// File: rtl/lwake_pkg.sv
package lwake_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK_ULPM,
        ST_PLL_WAIT,
        ST_EXIT_WAIT,
        ST_HOLD,
        ST_SWITCH,
        ST_STOP_CHK
    } wake_state_e;

    typedef struct packed {
        wake_state_e state;
        logic        pll_en;
        logic [3:0]  pwr_ctl;
        logic        clk_sel;
        logic        done;
        logic        err;
    } wake_regs_t;

    localparam logic [3:0] PWR_EXIT_ALL = 4'hF;
    localparam logic [3:0] PWR_RELEASE  = 4'h0;

endpackage

// File: rtl/lwake_lane_decode.sv
module lwake_lane_decode (
    input  logic       two_lane_i,
    input  logic [8:1] stat_i,
    output logic       all_ulpm_o,
    output logic       exit_ok_o,
    output logic       stop_ok_o
);
    always_comb begin
        if (two_lane_i) begin
            all_ulpm_o = (stat_i[8:1] == 8'h00);
            exit_ok_o  = stat_i[8] & stat_i[5] & stat_i[3];
            stop_ok_o  = (stat_i[8:4] == 5'b11011) & ~stat_i[1];
        end else begin
            all_ulpm_o = (stat_i[6:1] == 6'h00);
            exit_ok_o  = stat_i[5] & stat_i[3];
            stop_ok_o  = (stat_i[6:4] == 3'b011) & ~stat_i[1];
        end
    end
endmodule

// File: rtl/lwake_cycle_cnt.sv
module lwake_cycle_cnt #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic hit_o
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || !en_i || hit_o) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    assign hit_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R6
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> cnt_q == '0); // R9
endmodule

// File: rtl/lane_wake_seq.sv
module lane_wake_seq
    import lwake_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TMO_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       two_lane_i,
    input  logic       pll_lock_i,
    input  logic [8:1] lane_stat_i,
    output logic       pll_en_o,
    output logic [3:0] pwr_ctl_o,
    output logic       byteclk_sel_o,
    output logic       done_o,
    output logic       busy_o,
    output logic       err_o
);
    localparam int HOLD_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    wake_regs_t r_d, r_q;
    logic all_ulpm, exit_ok, stop_ok;
    logic hold_en, hold_hit;
    logic tmo_en, tmo_clr, tmo_hit;

    lwake_lane_decode u_decode (
        .two_lane_i (two_lane_i),
        .stat_i     (lane_stat_i),
        .all_ulpm_o (all_ulpm),
        .exit_ok_o  (exit_ok),
        .stop_ok_o  (stop_ok)
    );

    assign hold_en = (r_q.state == ST_HOLD);
    lwake_cycle_cnt #(.LIMIT(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (hold_en),
        .clr_i (1'b0),
        .hit_o (hold_hit)
    );

    assign tmo_en = (r_q.state == ST_CHK_ULPM) || (r_q.state == ST_PLL_WAIT) ||
                    (r_q.state == ST_EXIT_WAIT) || (r_q.state == ST_STOP_CHK);
    assign tmo_clr = (r_d.state != r_q.state);
    lwake_cycle_cnt #(.LIMIT(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (tmo_en),
        .clr_i (tmo_clr),
        .hit_o (tmo_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_CHK_ULPM;
                    r_d.clk_sel = 1'b0;
                end
            end
            ST_CHK_ULPM: begin
                if (all_ulpm) begin
                    r_d.pll_en = 1'b1;
                    r_d.state  = ST_PLL_WAIT;
                end else if (tmo_hit) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_PLL_WAIT: begin
                if (pll_lock_i) begin
                    r_d.pwr_ctl = PWR_EXIT_ALL;
                    r_d.state   = ST_EXIT_WAIT;
                end else if (tmo_hit) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_EXIT_WAIT: begin
                if (exit_ok) begin
                    r_d.state = ST_HOLD;
                end else if (tmo_hit) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (hold_hit) begin
                    r_d.pwr_ctl = PWR_RELEASE;
                    r_d.state   = ST_SWITCH;
                end
            end
            ST_SWITCH: begin
                r_d.clk_sel = 1'b1;
                r_d.state   = ST_STOP_CHK;
            end
            ST_STOP_CHK: begin
                if (stop_ok && r_q.pll_en) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (tmo_hit) begin
                    r_d.err   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.pll_en  <= 1'b0;
            r_q.pwr_ctl <= PWR_RELEASE;
            r_q.clk_sel <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.err     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pll_en_o      = r_q.pll_en;
    assign pwr_ctl_o     = r_q.pwr_ctl;
    assign byteclk_sel_o = r_q.clk_sel;
    assign done_o        = r_q.done;
    assign busy_o        = (r_q.state != ST_IDLE);
    assign err_o         = r_q.err;

    AST_EXIT_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ctl_o == PWR_EXIT_ALL |-> pll_en_o); // R3
    AST_EXIT_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ctl_o == PWR_EXIT_ALL && !$stable(pwr_ctl_o)) |-> $past(pll_lock_i)); // R4
    AST_CTL_TWO_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_ctl_o) |-> (pwr_ctl_o == PWR_EXIT_ALL || pwr_ctl_o == PWR_RELEASE)); // R4
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && $past(r_q.state) == ST_HOLD) |->
        ($stable(pwr_ctl_o) && $stable(pll_en_o) && $stable(byteclk_sel_o))); // R6
    AST_SEL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byteclk_sel_o) |-> pwr_ctl_o == PWR_RELEASE && $past(pwr_ctl_o) == PWR_RELEASE); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pll_en_o && byteclk_sel_o && pwr_ctl_o == PWR_RELEASE && !busy_o)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R11
endmodule

// File: tb/tb_lane_wake_seq.sv
module tb_lane_wake_seq;
    localparam int CLK_HZ = 16_000;
    localparam int TMO    = 12;
    localparam int HOLD   = CLK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       two_lane_i = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic [8:1] lane_stat_i = '0;
    logic       pll_en_o, byteclk_sel_o, done_o, busy_o, err_o;
    logic [3:0] pwr_ctl_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lane_wake_seq #(.CLK_HZ(CLK_HZ), .TMO_CYC(TMO)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .two_lane_i    (two_lane_i),
        .pll_lock_i    (pll_lock_i),
        .lane_stat_i   (lane_stat_i),
        .pll_en_o      (pll_en_o),
        .pwr_ctl_o     (pwr_ctl_o),
        .byteclk_sel_o (byteclk_sel_o),
        .done_o        (done_o),
        .busy_o        (busy_o),
        .err_o         (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 1'b0; pll_lock_i = 1'b0; lane_stat_i = '0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    function automatic logic [8:1] pat_exit(input bit two);
        logic [8:1] p = '0;
        p[5] = 1'b1; p[3] = 1'b1;
        if (two) p[8] = 1'b1;
        return p;
    endfunction

    function automatic logic [8:1] pat_stop(input bit two);
        logic [8:1] p = '0;
        p[5] = 1'b1; p[4] = 1'b1;
        if (two) begin p[8] = 1'b1; p[7] = 1'b1; end
        return p;
    endfunction

    task automatic run_full(input bit two, input bit inject, input bit bad_stop);
        int n;
        bit seen_done;
        do_reset();
        two_lane_i = two;
        pulse_start();
        chk(busy_o == 1'b1, "R11", int'(busy_o), 1);
        chk(pll_en_o == 1'b0, "R3", int'(pll_en_o), 0);
        tick();
        chk(pll_en_o == 1'b1, "R3", int'(pll_en_o), 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(pwr_ctl_o == 4'h0, "R3", int'(pwr_ctl_o), 0);
        end
        lane_stat_i = pat_exit(two);
        pll_lock_i  = 1'b1;
        tick();
        chk(pwr_ctl_o == 4'hF, "R4", int'(pwr_ctl_o), 15);
        n = 1;
        while (n < 100) begin
            start_i = (inject && n == 5);
            tick();
            if (pwr_ctl_o == 4'hF) n++;
            else break;
        end
        start_i = 1'b0;
        chk(n == HOLD + 1, "R6", n, HOLD + 1);
        chk(pwr_ctl_o == 4'h0, "R7", int'(pwr_ctl_o), 0);
        chk(byteclk_sel_o == 1'b0, "R7", int'(byteclk_sel_o), 0);
        lane_stat_i = pat_stop(two);
        if (bad_stop) lane_stat_i[1] = 1'b1;
        tick();
        chk(byteclk_sel_o == 1'b1, "R7", int'(byteclk_sel_o), 1);
        chk(done_o == 1'b0, "R8", int'(done_o), 0);
        if (!bad_stop) begin
            tick();
            chk(done_o == 1'b1, "R8", int'(done_o), 1);
            chk(busy_o == 1'b0, "R11", int'(busy_o), 0);
            chk(pll_en_o == 1'b1, "R8", int'(pll_en_o), 1);
            tick();
            chk(done_o == 1'b0, "R8", int'(done_o), 0);
            if (inject) chk(busy_o == 1'b0, "R10", int'(busy_o), 0);
        end else begin
            seen_done = 1'b0;
            for (int i = 0; i < TMO + 2; i++) begin
                tick();
                if (done_o) seen_done = 1'b1;
            end
            chk(!seen_done, "R8", int'(seen_done), 0);
            chk(err_o == 1'b1, "R9", int'(err_o), 1);
            chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
            chk(pll_en_o == 1'b1 && byteclk_sel_o == 1'b1, "R9", int'(pll_en_o), 1);
        end
        pll_lock_i = 1'b0;
    endtask

    task automatic ulpm_sweep();
        for (int two = 0; two < 2; two++) begin
            for (int b = 0; b <= 8; b++) begin
                int  n;
                bit  bad;
                do_reset();
                two_lane_i  = two[0];
                lane_stat_i = '0;
                if (b > 0) lane_stat_i[b] = 1'b1;
                bad = (b != 0) && (two == 1 || b <= 6);
                pulse_start();
                n = 0;
                while (busy_o && !pll_en_o && n < 50) begin
                    n++;
                    tick();
                end
                if (bad) begin
                    chk(pll_en_o == 1'b0, "R2", int'(pll_en_o), 0);
                    chk(n == TMO && err_o == 1'b1, "R9", n, TMO);
                end else begin
                    chk(pll_en_o == 1'b1 && err_o == 1'b0, "R2", int'(pll_en_o), 1);
                    chk(n == 1, "R3", n, 1);
                end
            end
        end
    endtask

    task automatic exit_mismatch();
        do_reset();
        two_lane_i = 1'b1;
        pulse_start();
        tick();
        lane_stat_i = pat_exit(1'b0);
        pll_lock_i  = 1'b1;
        tick();
        chk(pwr_ctl_o == 4'hF, "R4", int'(pwr_ctl_o), 15);
        repeat (TMO + 1) tick();
        chk(err_o == 1'b1, "R5", int'(err_o), 1);
        chk(pwr_ctl_o == 4'hF, "R9", int'(pwr_ctl_o), 15);
        chk(pll_en_o == 1'b1 && busy_o == 1'b0, "R9", int'(busy_o), 0);
        repeat (3) tick();
        chk(err_o == 1'b1, "R9", int'(err_o), 1);
        pll_lock_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) tick();
        chk(pll_en_o == 1'b0 && pwr_ctl_o == 4'h0, "R1", int'(pwr_ctl_o), 0);
        chk(byteclk_sel_o == 1'b0 && done_o == 1'b0, "R1", int'(byteclk_sel_o), 0);
        chk(busy_o == 1'b0 && err_o == 1'b0, "R1", int'(busy_o), 0);
        run_full(1'b0, 1'b0, 1'b0);
        run_full(1'b1, 1'b0, 1'b0);
        run_full(1'b1, 1'b1, 1'b0);
        run_full(1'b0, 1'b1, 1'b0);
        run_full(1'b1, 1'b0, 1'b1);
        run_full(1'b0, 1'b0, 1'b1);
        ulpm_sweep();
        exit_mismatch();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule